// File: doc/BRIEF.md
# Sector-Steered Bridge Gate Sequencer

This block drives the six main switches of a three-phase boost rectifier that runs under one-cycle control. The three phase-polarity bits divide the line cycle into six 60-degree sectors. In each sector the phase with the largest magnitude has a sign that differs from the other two. Only those other two phases are switched. Both of their switches sit on the same side of the bridge. The remaining four switches stay off, and their anti-parallel diodes carry the current.

Each switching period begins with a one-cycle strobe. At that strobe the block captures the sector, and both chosen switches turn on together. An external integrator and comparator pair (the p and n channels) then ends each switch's on-time on its own, in the way a set-reset flip-flop does. The sector and the routing can only change at a strobe, so the routing never moves in the middle of a period. The block has no analog front end and no dead-time insertion.

Top module: `rgs_gate_seq`

## Requirements
- R1: While rst_ni is low, all six gate outputs are low, region_o is 0 and pol_err_o is 0. This holds at once, with no clock edge needed.
- R2: pol_i carries phase a in bit 0, b in bit 1 and c in bit 2, where 1 means positive. A valid strobe loads region_o with the code below, visible after that clock edge: 101→1, 001→2, 011→3, 010→4, 110→5, 100→6.
- R3: When two phases are positive, the lower switches of those two phases are used (gate_dn_o, bit index = phase). When two phases are negative, their upper switches are used (gate_up_o).
- R4: On the clock edge that samples period_start_i high with a valid sector, both selected gates go high. The other four stay low.
- R5: The p channel drives the active phase with the lower index, and the n channel drives the one with the higher index. A trip input sampled high turns off only its own channel's gate, from that edge on.
- R6: A channel that has turned off stays off until the next strobe, even after its trip input has gone low again.
- R7: A trip input that is high on the strobe edge keeps its channel off for that whole period. Reset wins over set.
- R8: A change on pol_i between strobes changes neither region_o nor the gate routing.
- R9: A strobe with pol_i = 000 or 111 keeps the previous region and raises pol_err_o. The channels are still set on the held region. The next valid strobe clears pol_err_o.
- R10: Upper and lower gates are never high at the same time, and at most two gates are high.
- R11: Until a valid sector has been captured (region_o = 0), strobes drive no gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | One-cycle strobe that starts a switching period |
| pol_i | input | 3 | Phase polarity, bit0=a, bit1=b, bit2=c, 1=positive |
| trip_p_i | input | 1 | Turn-off request for the p channel (lower-index active phase) |
| trip_n_i | input | 1 | Turn-off request for the n channel (higher-index active phase) |
| gate_up_o | output | 3 | Upper switch gates, indexed by phase |
| gate_dn_o | output | 3 | Lower switch gates, indexed by phase |
| region_o | output | 3 | Current sector code 1..6, 0 before the first valid sector |
| pol_err_o | output | 1 | Invalid polarity seen at the last strobe |

## Verification
The hardest conditions to reach are the ones where a trip and a strobe meet, and where polarity moves away from the strobe edge. The stimulus holds trip_n_i high across a strobe to show that reset dominates. It releases a trip in the middle of a period and then checks that the gate stays low. It also changes pol_i several cycles before the next strobe and confirms that the old sector's gates are still active. Invalid polarity is sent both before any sector exists and after one has been captured, which covers both the held-region case and the no-region case.

// File: rtl/rgs_pkg.sv
package rgs_pkg;
  localparam int unsigned PH_N  = 3;
  localparam int unsigned CH_N  = 2;
  localparam int unsigned REG_W = 3;
  localparam int unsigned IDX_W = $clog2(PH_N);

  typedef logic [REG_W-1:0] region_t;

  typedef struct packed {
    logic             valid;
    logic             upper;
    logic [IDX_W-1:0] p_idx;
    logic [IDX_W-1:0] n_idx;
  } route_t;

  // sector -> side and the two phases, p = lower index
  function automatic route_t route_of(region_t r);
    route_t rt;
    rt = '0;
    case (r)
      3'd1: rt = '{1'b1, 1'b0, IDX_W'(0), IDX_W'(2)};
      3'd2: rt = '{1'b1, 1'b1, IDX_W'(1), IDX_W'(2)};
      3'd3: rt = '{1'b1, 1'b0, IDX_W'(0), IDX_W'(1)};
      3'd4: rt = '{1'b1, 1'b1, IDX_W'(0), IDX_W'(2)};
      3'd5: rt = '{1'b1, 1'b0, IDX_W'(1), IDX_W'(2)};
      3'd6: rt = '{1'b1, 1'b1, IDX_W'(0), IDX_W'(1)};
      default: rt = '0;
    endcase
    return rt;
  endfunction
endpackage

// File: rtl/rgs_sector_decode.sv
module rgs_sector_decode
  import rgs_pkg::*;
(
  input  logic [PH_N-1:0] pol_i,
  output region_t         region_o,
  output logic            valid_o
);
  always_comb begin
    valid_o  = 1'b1;
    region_o = '0;
    case (pol_i)
      3'b101: region_o = 3'd1;
      3'b001: region_o = 3'd2;
      3'b011: region_o = 3'd3;
      3'b010: region_o = 3'd4;
      3'b110: region_o = 3'd5;
      3'b100: region_o = 3'd6;
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rgs_trip_latch.sv
module rgs_trip_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] trip_i,
  output logic [N-1:0] on_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic on_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        on_q <= 1'b0;
      else if (trip_i[i]) on_q <= 1'b0;  // reset dominant
      else if (start_i)   on_q <= 1'b1;
    end
    assign on_o[i] = on_q;

    p_trip_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_i[i] |=> !on_o[i]);
    p_no_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !on_o[i]) |=> !on_o[i]);
    p_set_on_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !trip_i[i]) |=> on_o[i]);
  end
endmodule

// File: rtl/rgs_gate_route.sv
module rgs_gate_route
  import rgs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  region_t         region_i,
  input  logic [CH_N-1:0] on_i,
  output logic [PH_N-1:0] gate_up_o,
  output logic [PH_N-1:0] gate_dn_o
);
  route_t rt;
  assign rt = route_of(region_i);

  for (genvar k = 0; k < PH_N; k++) begin : g_ph
    logic drive;
    assign drive = rt.valid &
                   ((rt.p_idx == IDX_W'(k) && on_i[0]) ||
                    (rt.n_idx == IDX_W'(k) && on_i[1]));
    assign gate_up_o[k] = drive &  rt.upper;
    assign gate_dn_o[k] = drive & ~rt.upper;
  end

  p_no_mixed_side_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|gate_up_o) && (|gate_dn_o)));
  p_max_two_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({gate_up_o, gate_dn_o}) <= 2);
  p_idle_region_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_i == '0) |-> (gate_up_o == '0 && gate_dn_o == '0));
endmodule

// File: rtl/rgs_gate_seq.sv
module rgs_gate_seq
  import rgs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        period_start_i,
  input  logic [2:0]  pol_i,
  input  logic        trip_p_i,
  input  logic        trip_n_i,
  output logic [2:0]  gate_up_o,
  output logic [2:0]  gate_dn_o,
  output logic [2:0]  region_o,
  output logic        pol_err_o
);
  region_t         dec_region;
  logic            dec_valid;
  region_t         region_q;
  logic            err_q;
  logic [CH_N-1:0] ch_on;

  rgs_sector_decode u_dec (
    .pol_i    (pol_i),
    .region_o (dec_region),
    .valid_o  (dec_valid)
  );

  // sector captured only at period start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= '0;
      err_q    <= 1'b0;
    end else if (period_start_i) begin
      if (dec_valid) begin
        region_q <= dec_region;
        err_q    <= 1'b0;
      end else begin
        err_q    <= 1'b1;
      end
    end
  end

  rgs_trip_latch #(.N(CH_N)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (period_start_i),
    .trip_i  ({trip_n_i, trip_p_i}),
    .on_o    (ch_on)
  );

  rgs_gate_route u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .region_i  (region_q),
    .on_i      (ch_on),
    .gate_up_o (gate_up_o),
    .gate_dn_o (gate_dn_o)
  );

  assign region_o  = region_q;
  assign pol_err_o = err_q;

  p_region_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_i |=> $stable(region_o));
  p_invalid_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_start_i && (pol_i == 3'b000 || pol_i == 3'b111))
      |=> ($stable(region_o) && pol_err_o));
  p_rise_on_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((gate_up_o & ~$past(gate_up_o)) | (gate_dn_o & ~$past(gate_dn_o))) != '0)
      |-> $past(period_start_i));
  p_region_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_o <= 3'd6);
endmodule

// File: tb/tb_rgs_gate_seq.sv
`timescale 1ns/1ps
module tb_rgs_gate_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       period_start_i = 1'b0;
  logic [2:0] pol_i = 3'b000;
  logic       trip_p_i = 1'b0;
  logic       trip_n_i = 1'b0;
  logic [2:0] gate_up_o, gate_dn_o, region_o;
  logic       pol_err_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rgs_gate_seq dut (.*);

  // {pol, region, upper, p_mask, n_mask}
  localparam logic [12:0] VEC [6] = '{
    {3'b101, 3'd1, 1'b0, 3'b001, 3'b100},
    {3'b001, 3'd2, 1'b1, 3'b010, 3'b100},
    {3'b011, 3'd3, 1'b0, 3'b001, 3'b010},
    {3'b010, 3'd4, 1'b1, 3'b001, 3'b100},
    {3'b110, 3'd5, 1'b0, 3'b010, 3'b100},
    {3'b100, 3'd6, 1'b1, 3'b001, 3'b010}
  };

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string tag, logic up_side, logic [2:0] mask,
                     logic [2:0] reg_e, logic err_e);
    logic [9:0] act, exp;
    act = {gate_up_o, gate_dn_o, region_o, pol_err_o};
    exp = {up_side ? mask : 3'b000, up_side ? 3'b000 : mask, reg_e, err_e};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act up=%b dn=%b reg=%0d err=%b exp up=%b dn=%b reg=%0d err=%b",
               tag, act[9:7], act[6:4], act[3:1], act[0],
               exp[9:7], exp[6:4], exp[3:1], exp[0]);
    end
  endtask

  task automatic strobe(logic [2:0] p);
    pol_i = p; period_start_i = 1'b1;
    tick();
    period_start_i = 1'b0;
  endtask

  initial begin
    #1;
    chk("R1 reset", 1'b0, 3'b000, 3'd0, 1'b0);
    tick(); tick();
    rst_ni = 1'b1;
    tick();

    // R11 / R9: invalid first strobe, no region yet
    strobe(3'b000);
    chk("R11 R9 no region", 1'b0, 3'b000, 3'd0, 1'b1);

    // R2 R3 R4 R5 R6 R10 table walk
    for (int i = 0; i < 6; i++) begin
      logic [2:0] rg, pm, nm;
      logic up;
      rg = VEC[i][9:7]; up = VEC[i][6]; pm = VEC[i][5:3]; nm = VEC[i][2:0];
      strobe(VEC[i][12:10]);
      chk("R2 R3 R4 R10 both on", up, pm | nm, rg, 1'b0);
      trip_p_i = 1'b1; tick();
      chk("R5 p off", up, nm, rg, 1'b0);
      trip_p_i = 1'b0; tick();
      chk("R6 p stays off", up, nm, rg, 1'b0);
      trip_n_i = 1'b1; tick();
      chk("R5 n off", up, 3'b000, rg, 1'b0);
      trip_n_i = 1'b0; tick();
      chk("R6 both stay off", up, 3'b000, rg, 1'b0);
    end

    // R8: polarity moves mid-period
    strobe(3'b101);
    pol_i = 3'b010;
    tick(); tick(); tick();
    chk("R8 mid-period pol change", 1'b0, 3'b101, 3'd1, 1'b0);
    strobe(3'b010);
    chk("R8 applied at strobe", 1'b1, 3'b101, 3'd4, 1'b0);

    // R7: trip held across strobe
    trip_n_i = 1'b1;
    strobe(3'b011);
    chk("R7 n held off at strobe", 1'b0, 3'b001, 3'd3, 1'b0);
    trip_n_i = 1'b0; tick();
    chk("R7 R6 n still off", 1'b0, 3'b001, 3'd3, 1'b0);

    // R9: invalid after valid region
    strobe(3'b111);
    chk("R9 hold on 111", 1'b0, 3'b011, 3'd3, 1'b1);
    strobe(3'b000);
    chk("R9 hold on 000", 1'b0, 3'b011, 3'd3, 1'b1);
    strobe(3'b100);
    chk("R9 err clears", 1'b1, 3'b011, 3'd6, 1'b0);

    // R1: async reset mid-period
    #1 rst_ni = 1'b0; #1;
    chk("R1 async reset", 1'b0, 3'b000, 3'd0, 1'b0);
    tick(); rst_ni = 1'b1; tick();
    chk("R1 after release", 1'b0, 3'b000, 3'd0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule